// File: doc/BRIEF.md
# CAN Controller Test-Mode Unit

This block is the test-mode corner of a CAN controller. It holds one 32-bit test register. Software may change the register only while a separate test-enable input is high. The writable fields choose how the bus transmit pin is driven and whether the controller's receive path is looped back onto its own transmit bit. The read-only fields show the synchronized level of the bus receive pin and two transmit-buffer status numbers, each with a valid flag.

The protocol engine, bit timing and message buffers lie outside this block. They appear only as inputs:

- the core's transmit bit;
- an end-of-bit-time strobe;
- a sample-point strobe;
- the two buffer numbers and their valid flags.

The block drives the bus transmit pin. It also drives the receive bit handed back to the core.

Top module: `can_test_ctrl`

## Requirements
- R1: After reset, a read of the test register returns 0x00000080 when the bus receive pin is recessive and all status inputs are zero. After reset the bus transmit pin is recessive (1).
- R2: While test_en is 1, a write to offset 0x10 loads bits 6:5 (transmit-pin select) and bit 4 (loop-back enable) from the write data. A following read returns them in the same positions.
- R3: A write issued while test_en is 0 changes no field, including after test_en is raised again.
- R4: When test_en is 0, bits 6:4 read as zero and the pin and loop-back behave as select 0 with loop-back off, from the same cycle test_en falls. The stored fields are also cleared by the next clock, so raising test_en again still reads zero.
- R5: Write data in bits 31:7 and 3:0 has no effect. Bits 31:22, 15:14 and 3:0 always read as zero.
- R6: reg_rdata carries the register image in the same cycle that reg_rd is high with reg_addr equal to 0x10, and is zero otherwise. Writes to any other address change nothing.
- R7: With select 0, bus_tx shows the value core_tx had at the last clock edge where core_bit_end was high. bus_tx changes in the cycle after that edge.
- R8: With select 1, bus_tx is 0 in every cycle where core_sp is 1, and 1 otherwise.
- R9: With select 2, bus_tx is 0. With select 3, bus_tx is 1.
- R10: Bit 7 of the read image equals bus_rx delayed by two clock edges, through a two-flop synchronizer that resets to 1.
- R11: With loop-back on, core_rx equals core_tx in the same cycle. With loop-back off, core_rx equals the synchronized receive level of R10.
- R12: Read bits 20:16 show start_num, bit 21 start_vld, bits 12:8 prep_num and bit 13 prep_vld, all in the same cycle as the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| test_en | input | 1 | Test-mode enable; gates writes and clears the fields when low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle |
| core_tx | input | 1 | Transmit bit from the protocol core |
| core_bit_end | input | 1 | End-of-bit-time strobe from the core |
| core_sp | input | 1 | Sample-point strobe from the core |
| core_rx | output | 1 | Receive bit presented to the core |
| start_num | input | 5 | Number of the buffer whose transmission started last |
| start_vld | input | 1 | start_num is valid |
| prep_num | input | 5 | Number of the buffer prepared for transmission |
| prep_vld | input | 1 | prep_num is valid |
| bus_rx | input | 1 | Bus receive pin |
| bus_tx | output | 1 | Bus transmit pin |

## Verification
The bench targets the falling edge of test_en with forced-dominant drive and loop-back both active. A design that clears the fields only at the next clock would still pull the pin low, or loop the core back to itself, in that first cycle. Writes carry pseudo-random values in the read-only bits. A design that stored those bits would show them on read-back. The bench also sweeps all four pin selects against both loop-back settings and checks the exact cycle in which bus_tx follows a bit-end strobe and in which bit 7 follows the receive pin. An off-by-one register would show one cycle early or late. Every buffer number, paired with both valid settings, is read back to catch a shifted or swapped status field.

// File: rtl/can_test_pkg.sv
package can_test_pkg;

  localparam int REG_W     = 32;
  localparam int BUFNUM_W  = 5;
  localparam int TXSEL_W   = 2;

  // bit positions in the test register image
  localparam int LBK_BIT       = 4;
  localparam int TXSEL_LSB     = 5;
  localparam int RXPIN_BIT     = 7;
  localparam int PREP_LSB      = 8;
  localparam int PREP_VLD_BIT  = 13;
  localparam int START_LSB     = 16;
  localparam int START_VLD_BIT = 21;

  typedef enum logic [TXSEL_W-1:0] {
    TXSEL_CORE  = 2'd0,
    TXSEL_SPMON = 2'd1,
    TXSEL_DOM   = 2'd2,
    TXSEL_REC   = 2'd3
  } txsel_e;

  typedef struct packed {
    txsel_e txsel;
    logic   loopback;
  } test_fields_t;

endpackage

// File: rtl/cantest_sync.sv
module cantest_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] stage_q;
  logic [LAST:0] stage_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stage_d = din;
    end else begin : g_chain
      always_comb stage_d = {stage_q[LAST-1:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RST_VAL}};
    else        stage_q <= stage_d;
  end

  assign dout = stage_q[LAST];

endmodule

// File: rtl/cantest_fields.sv
module cantest_fields
  import can_test_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int unsigned TEST_OFFSET = 32'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output test_fields_t      fields_eff
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(TEST_OFFSET);

  test_fields_t fields_q;
  test_fields_t fields_d;
  logic         addr_hit;
  logic         fld_ce;
  logic         unused_wr_bits;

  assign addr_hit       = (wr_addr == HIT_ADDR);
  assign unused_wr_bits = ^{wr_data[REG_W-1:RXPIN_BIT], wr_data[LBK_BIT-1:0]};

  // next-state: clear while test mode is off, load on an accepted write
  always_comb begin
    fld_ce   = 1'b0;
    fields_d = fields_q;
    if (!test_en) begin
      fld_ce   = 1'b1;
      fields_d = '0;
    end else if (wr_en && addr_hit) begin
      fld_ce            = 1'b1;
      fields_d.txsel    = txsel_e'(wr_data[TXSEL_LSB +: TXSEL_W]);
      fields_d.loopback = wr_data[LBK_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fields_q <= '0;
    else if (fld_ce) fields_q <= fields_d;
  end

  // the fields take their reset value in the same cycle test mode drops
  assign fields_eff = test_en ? fields_q : '0;

endmodule

// File: rtl/cantest_txdrv.sv
module cantest_txdrv
  import can_test_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  txsel_e txsel,
  input  logic   core_tx,
  input  logic   core_bit_end,
  input  logic   core_sp,
  output logic   bus_tx
);

  logic bit_q;
  logic bit_d;

  assign bit_d = core_tx;

  // core bit held for a whole bit time, reloaded on each bit-end strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            bit_q <= 1'b1;
    else if (core_bit_end) bit_q <= bit_d;
  end

  always_comb begin
    unique case (txsel)
      TXSEL_CORE:  bus_tx = bit_q;
      TXSEL_SPMON: bus_tx = ~core_sp;
      TXSEL_DOM:   bus_tx = 1'b0;
      TXSEL_REC:   bus_tx = 1'b1;
      default:     bus_tx = 1'b1;
    endcase
  end

endmodule

// File: rtl/cantest_rdmux.sv
module cantest_rdmux
  import can_test_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int unsigned TEST_OFFSET = 32'h10
) (
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  test_fields_t        fields,
  input  logic                rx_level,
  input  logic [BUFNUM_W-1:0] start_num,
  input  logic                start_vld,
  input  logic [BUFNUM_W-1:0] prep_num,
  input  logic                prep_vld,
  output logic [REG_W-1:0]    rdata
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(TEST_OFFSET);

  logic [REG_W-1:0] image;

  always_comb begin
    image                           = '0;
    image[LBK_BIT]                  = fields.loopback;
    image[TXSEL_LSB +: TXSEL_W]     = fields.txsel;
    image[RXPIN_BIT]                = rx_level;
    image[PREP_LSB +: BUFNUM_W]     = prep_num;
    image[PREP_VLD_BIT]             = prep_vld;
    image[START_LSB +: BUFNUM_W]    = start_num;
    image[START_VLD_BIT]            = start_vld;
  end

  assign rdata = (rd_en && (rd_addr == HIT_ADDR)) ? image : '0;

endmodule

// File: rtl/can_test_ctrl.sv
module can_test_ctrl
  import can_test_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int unsigned TEST_OFFSET = 32'h10,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                test_en,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic                core_tx,
  input  logic                core_bit_end,
  input  logic                core_sp,
  output logic                core_rx,
  input  logic [BUFNUM_W-1:0] start_num,
  input  logic                start_vld,
  input  logic [BUFNUM_W-1:0] prep_num,
  input  logic                prep_vld,
  input  logic                bus_rx,
  output logic                bus_tx
);

  test_fields_t        fld_eff;
  logic                rx_lvl;
  logic [TXSEL_W-1:0]  txsel_eff;
  logic                lb_eff;

  cantest_fields #(
    .ADDR_W      (ADDR_W),
    .TEST_OFFSET (TEST_OFFSET)
  ) i_fields (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_en    (test_en),
    .wr_en      (reg_wr),
    .wr_addr    (reg_addr),
    .wr_data    (reg_wdata),
    .fields_eff (fld_eff)
  );

  cantest_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) i_rx_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (bus_rx),
    .dout  (rx_lvl)
  );

  cantest_txdrv i_txdrv (
    .clk          (clk),
    .rst_n        (rst_n),
    .txsel        (fld_eff.txsel),
    .core_tx      (core_tx),
    .core_bit_end (core_bit_end),
    .core_sp      (core_sp),
    .bus_tx       (bus_tx)
  );

  cantest_rdmux #(
    .ADDR_W      (ADDR_W),
    .TEST_OFFSET (TEST_OFFSET)
  ) i_rdmux (
    .rd_en     (reg_rd),
    .rd_addr   (reg_addr),
    .fields    (fld_eff),
    .rx_level  (rx_lvl),
    .start_num (start_num),
    .start_vld (start_vld),
    .prep_num  (prep_num),
    .prep_vld  (prep_vld),
    .rdata     (reg_rdata)
  );

  assign txsel_eff = fld_eff.txsel;
  assign lb_eff    = fld_eff.loopback;

  // loop-back feeds the core its own transmit bit
  assign core_rx = lb_eff ? core_tx : rx_lvl;

endmodule

// File: rtl/can_test_ctrl_chk.sv
module can_test_ctrl_chk #(
  parameter int          ADDR_W      = 8,
  parameter int unsigned TEST_OFFSET = 32'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              test_en,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              core_tx,
  input logic              core_bit_end,
  input logic              core_sp,
  input logic              core_rx,
  input logic [4:0]        start_num,
  input logic              start_vld,
  input logic [4:0]        prep_num,
  input logic              prep_vld,
  input logic              bus_rx,
  input logic              bus_tx,
  input logic [1:0]        txsel,
  input logic              loopback,
  input logic              rx_sync
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(TEST_OFFSET);

  logic [1:0] cyc_cnt;
  logic       rd_hit;

  assign rd_hit = reg_rd && (reg_addr == HIT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cyc_cnt <= 2'd0;
    else if (cyc_cnt != 2'd3)   cyc_cnt <= cyc_cnt + 2'd1;
  end

  assert_fields_zero_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !test_en) |-> (reg_rdata[6:4] == 3'b000));

  assert_no_write_while_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_cnt != 2'd0 && test_en && $past(!test_en)) |-> (txsel == 2'd0 && !loopback));

  assert_ro_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (reg_rdata[31:22] == 10'd0 && reg_rdata[15:14] == 2'd0 && reg_rdata[3:0] == 4'd0));

  assert_idle_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (reg_rdata == 32'd0));

  assert_bit_end_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_cnt != 2'd0 && txsel == 2'd0 && $past(core_bit_end)) |-> (bus_tx == $past(core_tx)));

  assert_sample_point_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (txsel == 2'd1) |-> (bus_tx == !core_sp));

  assert_forced_dom_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (txsel == 2'd2) |-> !bus_tx);

  assert_forced_rec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (txsel == 2'd3) |-> bus_tx);

  assert_rx_sync_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_cnt >= 2'd2) |-> (rx_sync == $past(bus_rx, 2)));

  assert_loopback_R11: assert property (@(posedge clk) disable iff (!rst_n)
    loopback |-> (core_rx == core_tx));

  assert_normal_rx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !loopback |-> (core_rx == rx_sync));

  assert_status_fields_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (reg_rdata[21:16] == {start_vld, start_num} && reg_rdata[13:8] == {prep_vld, prep_num}));

endmodule

bind can_test_ctrl can_test_ctrl_chk #(
  .ADDR_W      (ADDR_W),
  .TEST_OFFSET (TEST_OFFSET)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .test_en      (test_en),
  .reg_rd       (reg_rd),
  .reg_addr     (reg_addr),
  .reg_rdata    (reg_rdata),
  .core_tx      (core_tx),
  .core_bit_end (core_bit_end),
  .core_sp      (core_sp),
  .core_rx      (core_rx),
  .start_num    (start_num),
  .start_vld    (start_vld),
  .prep_num     (prep_num),
  .prep_vld     (prep_vld),
  .bus_rx       (bus_rx),
  .bus_tx       (bus_tx),
  .txsel        (txsel_eff),
  .loopback     (lb_eff),
  .rx_sync      (rx_lvl)
);

// File: tb/test_can_test_ctrl.sv
`timescale 1ns/1ps
module test_can_test_ctrl;

  localparam int          AW  = 8;
  localparam logic [7:0]  OFF = 8'h10;

  logic        clk;
  logic        rst_n;
  logic        test_en;
  logic        reg_wr;
  logic        reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        core_tx;
  logic        core_bit_end;
  logic        core_sp;
  logic        core_rx;
  logic [4:0]  start_num;
  logic        start_vld;
  logic [4:0]  prep_num;
  logic        prep_vld;
  logic        bus_rx;
  logic        bus_tx;

  int n_cmp;
  int n_bad;
  bit done;

  // bench model of the writable fields and the held core bit
  logic [1:0]  exp_sel;
  logic        exp_lb;
  logic        exp_bit;
  logic        exp_rx;
  logic [31:0] lfsr;

  can_test_ctrl #(.ADDR_W(AW), .TEST_OFFSET(32'h10), .SYNC_STAGES(2)) i_can_test_ctrl (
    .clk(clk), .rst_n(rst_n), .test_en(test_en),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .core_tx(core_tx), .core_bit_end(core_bit_end), .core_sp(core_sp), .core_rx(core_rx),
    .start_num(start_num), .start_vld(start_vld), .prep_num(prep_num), .prep_vld(prep_vld),
    .bus_rx(bus_rx), .bus_tx(bus_tx)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] image(input logic [1:0] sel, input logic lb, input logic rx,
                                        input logic [4:0] sn, input logic sv,
                                        input logic [4:0] pn, input logic pv);
    return (32'(sv) << 21) | (32'(sn) << 16) | (32'(pv) << 13) | (32'(pn) << 8)
         | (32'(rx) << 7) | (32'(sel) << 5) | (32'(lb) << 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (test_en && a == OFF) begin
      exp_sel = d[6:5];
      exp_lb  = d[4];
    end
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1;
    d = reg_rdata;
    reg_rd = 1'b0;
    #1;
  endtask

  function automatic logic [31:0] cur_img();
    return image(test_en ? exp_sel : 2'd0, test_en ? exp_lb : 1'b0, exp_rx,
                 start_num, start_vld, prep_num, prep_vld);
  endfunction

  initial begin
    logic [31:0] rv;
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; test_en = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_addr = '0; reg_wdata = '0; core_tx = 1'b1; core_bit_end = 1'b0; core_sp = 1'b0;
    start_num = '0; start_vld = 1'b0; prep_num = '0; prep_vld = 1'b0; bus_rx = 1'b1;
    exp_sel = 2'd0; exp_lb = 1'b0; exp_bit = 1'b1; exp_rx = 1'b1; lfsr = 32'hACE1_2468;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R1: reset image and pin
    rd(OFF, rv);
    chk("R1 reset image", rv, 32'h0000_0080);
    chk("R1 reset bus_tx", {31'd0, bus_tx}, 32'd1);

    // R3: write while test mode is off
    wr(OFF, 32'hFFFF_FFFF);
    rd(OFF, rv);
    chk("R3 write ignored (off)", rv, cur_img());
    @(negedge clk); test_en = 1'b1; #1;
    rd(OFF, rv);
    chk("R3 still reset after enable", rv, image(2'd0, 1'b0, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0));

    // R2/R5/R7/R8/R9/R11 sweep over every select and loop-back value
    for (int s = 0; s < 4; s++) begin
      for (int l = 0; l < 2; l++) begin
        step_lfsr();
        wr(OFF, (lfsr & ~32'h70) | (32'(s) << 5) | (32'(l) << 4));
        rd(OFF, rv);
        chk("R2 field read-back", rv[6:4], {30'd0, s[1:0], l[0]} & 32'h7);
        chk("R5 read-only bits untouched", rv, cur_img());
        case (s)
          0: begin
            for (int v = 0; v < 2; v++) begin
              @(negedge clk);
              core_tx = v[0]; core_bit_end = 1'b1; #1;
              chk("R7 holds before strobe edge", {31'd0, bus_tx}, {31'd0, exp_bit});
              @(negedge clk);
              core_bit_end = 1'b0; core_tx = ~v[0]; exp_bit = v[0]; #1;
              chk("R7 follows bit-end capture", {31'd0, bus_tx}, {31'd0, exp_bit});
              @(negedge clk); #1;
              chk("R7 held without strobe", {31'd0, bus_tx}, {31'd0, exp_bit});
            end
          end
          1: begin
            core_sp = 1'b0; #1;
            chk("R8 idle recessive", {31'd0, bus_tx}, 32'd1);
            core_sp = 1'b1; #1;
            chk("R8 strobe low", {31'd0, bus_tx}, 32'd0);
            core_sp = 1'b0; #1;
          end
          2: chk("R9 forced dominant", {31'd0, bus_tx}, 32'd0);
          default: chk("R9 forced recessive", {31'd0, bus_tx}, 32'd1);
        endcase
        for (int t = 0; t < 2; t++) begin
          core_tx = t[0]; #1;
          chk("R11 core_rx source", {31'd0, core_rx}, {31'd0, (l != 0) ? t[0] : exp_rx});
        end
      end
    end

    // R6: address decode and strobe gating
    wr(OFF, 32'h0000_0050);
    rd(8'h14, rv);
    chk("R6 other address reads zero", rv, 32'd0);
    reg_addr = OFF; #1;
    chk("R6 no strobe reads zero", reg_rdata, 32'd0);
    wr(8'h14, 32'h0000_0060);
    wr(8'h00, 32'h0000_0010);
    rd(OFF, rv);
    chk("R6 other-address write ignored", rv, cur_img());

    // R12: every buffer number with both valid settings
    for (int n = 0; n < 32; n++) begin
      for (int v = 0; v < 2; v++) begin
        start_num = 5'(n); start_vld = v[0];
        prep_num = 5'(31 - n); prep_vld = ~v[0]; #1;
        rd(OFF, rv);
        chk("R12 status fields", rv, cur_img());
      end
    end

    // R10: two-edge receive synchronizer, visible on bit 7 and core_rx
    wr(OFF, 32'h0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      bus_rx = ~bus_rx; #1;
      rd(OFF, rv);
      chk("R10 unchanged before edges", {31'd0, rv[7]}, {31'd0, exp_rx});
      @(negedge clk); #1;
      rd(OFF, rv);
      chk("R10 unchanged after one edge", {31'd0, rv[7]}, {31'd0, exp_rx});
      @(negedge clk); #1;
      exp_rx = bus_rx;
      rd(OFF, rv);
      chk("R10 visible after two edges", {31'd0, rv[7]}, {31'd0, exp_rx});
      chk("R11 core_rx follows synced rx", {31'd0, core_rx}, {31'd0, exp_rx});
    end

    // R4: drop test mode with forced dominant and loop-back active
    wr(OFF, 32'h0000_0050);
    core_tx = ~exp_rx; #1;
    chk("R4 precondition dominant", {31'd0, bus_tx}, 32'd0);
    @(negedge clk);
    test_en = 1'b0; #1;
    rd(OFF, rv);
    chk("R4 fields zero same cycle", rv, cur_img());
    chk("R4 pin core-driven same cycle", {31'd0, bus_tx}, {31'd0, exp_bit});
    chk("R4 loop-back off same cycle", {31'd0, core_rx}, {31'd0, exp_rx});
    @(negedge clk);
    test_en = 1'b1; exp_sel = 2'd0; exp_lb = 1'b0; #1;
    rd(OFF, rv);
    chk("R4 cleared after re-enable", rv, cur_img());

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule